// File: doc/BRIEF.md
# Per-Circuit Linked-List Cell Queue Manager

This block buffers fixed-size ATM cells in one shared on-chip cell store. It keeps a separate FIFO chain for every virtual circuit, so each circuit's cells leave in arrival order. It also keeps service queues, one for each pair of output port and priority level. A circuit sits in the service queue for its port and priority while it has cells waiting. Cells enter as a stream of 32-bit words tagged with a circuit index. Cells leave whenever a port is marked ready, so a congested port never holds back traffic bound for other ports.

A per-circuit table holds each circuit's output port, priority, length limit, current length, high-water length and loss counter. A configuration write sets the port, priority and limit of one circuit and clears its statistics. A statistics read port shows one circuit's counters at a time. A cell is dropped when it arrives and the store is full, or when its circuit has already reached its limit. The drop is recorded in that circuit's loss counter.

Top module: `vc_cell_queue`

## Requirements
- R1: A cell is 14 words. The first word is marked by `inSof`. An accepted cell leaves as 14 words on 14 consecutive cycles, with `outSof` on the first word, `outEop` on the last word, and the data unchanged.
- R2: Cells of one circuit leave in the order they arrived.
- R3: A cell is started only on a port whose `portReady` bit is 1. Cells for ports that are not ready wait, and they do not hold back cells for ready ports.
- R4: On one port, a circuit with a higher numeric priority (1 above 0) is fully served before a waiting lower-priority circuit.
- R5: Circuits of equal priority on one port take turns cell by cell. After it sends a cell, a circuit goes to the tail of its service queue.
- R6: Ready ports with waiting cells are served in rotation. After port p is served, the search begins at port p+1, wrapping to port 0.
- R7: A cell that arrives for a circuit whose length equals its limit is discarded. The circuit's loss counter rises by 1 and its length stays the same.
- R8: A cell that arrives while all 16 buffer slots are occupied is discarded and counted as a loss. Slots are reused once their cells have left.
- R9: `statLen` shows the current length of the circuit selected by `statVc`, and `statMax` shows the highest length it has reached. A configuration write clears the high-water mark and the loss counter of that circuit.
- R10: After reset there is no output, every circuit length and loss count is zero, and all slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inSof | input | 1 | Input word is the first word of a cell |
| inVc | input | 3 | Circuit index, sampled with `inSof` |
| inData | input | 32 | Input cell word |
| cfgWe | input | 1 | Configuration write strobe |
| cfgVc | input | 3 | Circuit being configured |
| cfgPort | input | 2 | Output port for that circuit |
| cfgPrio | input | 1 | Priority for that circuit (1 is higher) |
| cfgLimit | input | 5 | Maximum queue length for that circuit |
| statVc | input | 3 | Circuit whose statistics are shown |
| statLen | output | 5 | Current queue length |
| statMax | output | 5 | Highest queue length since the last configuration write |
| statLoss | output | 8 | Dropped-cell count (saturating) |
| portReady | input | 4 | One bit per port; 1 means the port is not congested |
| outValid | output | 1 | Output word valid |
| outSof | output | 1 | First word of an output cell |
| outEop | output | 1 | Last word of an output cell |
| outPort | output | 2 | Destination port of the current output cell |
| outVc | output | 3 | Circuit of the current output cell |
| outData | output | 32 | Output cell word |

## Verification
Some properties are checked on every cycle:
- each output cell is an unbroken burst,
- a cell never starts on a port that was not ready when it was picked,
- an arrival that meets a full store or a circuit at its limit is never kept,
- cell-store writes stay inside a slot.

Other behaviour only shows across a whole scenario, so the directed scenarios cover it: per-circuit ordering, priority ordering, turn-taking among equal circuits, port rotation, the statistics counters and slot reuse after the store has been full.

// File: rtl/vc_cell_queue_pkg.sv
package vc_cell_queue_pkg;
  localparam int CELL_WORDS = 14;
  localparam int WORD_W     = 32;
  localparam int BUF_CELLS  = 16;
  localparam int SLOT_W     = $clog2(BUF_CELLS);
  localparam int WIDX_W     = $clog2(CELL_WORDS);

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [WIDX_W-1:0] wrWord;
    logic [SLOT_W-1:0] rdSlot;
    logic [WIDX_W-1:0] rdWord;
  } memStrobe_t;
endpackage

// File: rtl/vc_cell_store.sv
module vc_cell_store
  import vc_cell_queue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        stb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH  = BUF_CELLS * CELL_WORDS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  assign wrAddr = ADDR_W'(stb.wrSlot) * ADDR_W'(CELL_WORDS) + ADDR_W'(stb.wrWord);
  assign rdAddr = ADDR_W'(stb.rdSlot) * ADDR_W'(CELL_WORDS) + ADDR_W'(stb.rdWord);

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];

  AST_WR_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (int'(stb.wrWord) < CELL_WORDS)); // R1
endmodule

// File: rtl/vc_queue_ctrl.sv
module vc_queue_ctrl
  import vc_cell_queue_pkg::*;
#(
  parameter int NUM_VC   = 8,
  parameter int NUM_PORT = 4,
  parameter int NUM_PRIO = 2,
  parameter int LOSS_W   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inSof,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     inVc,
  input  logic cfgWe,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     cfgVc,
  input  logic [((NUM_PORT>1)?$clog2(NUM_PORT):1)-1:0] cfgPort,
  input  logic [((NUM_PRIO>1)?$clog2(NUM_PRIO):1)-1:0] cfgPrio,
  input  logic [$clog2(BUF_CELLS+1)-1:0]               cfgLimit,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     statVc,
  output logic [$clog2(BUF_CELLS+1)-1:0]               statLen,
  output logic [$clog2(BUF_CELLS+1)-1:0]               statMax,
  output logic [LOSS_W-1:0]                            statLoss,
  input  logic [NUM_PORT-1:0]                          portReady,
  output logic outValid,
  output logic outSof,
  output logic outEop,
  output logic [((NUM_PORT>1)?$clog2(NUM_PORT):1)-1:0] outPort,
  output logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     outVc,
  output memStrobe_t stb
);
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
  localparam int PORT_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;
  localparam int PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
  localparam int LEN_W  = $clog2(BUF_CELLS + 1);
  localparam int NUM_Q  = NUM_PORT * NUM_PRIO;
  localparam int Q_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(CELL_WORDS - 1);

  // Cell chains and free slots
  logic [BUF_CELLS-1:0] freeMask;
  logic [SLOT_W-1:0]    cellNext [BUF_CELLS];
  // Per-circuit table
  logic [SLOT_W-1:0] vcHead [NUM_VC], vcTail [NUM_VC];
  logic [LEN_W-1:0]  vcLen [NUM_VC], vcMax [NUM_VC], vcLimit [NUM_VC];
  logic [LOSS_W-1:0] vcLoss [NUM_VC];
  logic [PORT_W-1:0] vcPort [NUM_VC];
  logic [PRIO_W-1:0] vcPrio [NUM_VC];
  logic [VC_W-1:0]   svcNext [NUM_VC];
  // Service queues, one for each port and priority
  logic [VC_W-1:0] qHead [NUM_Q], qTail [NUM_Q];
  logic [NUM_Q-1:0] qValid;
  // Enqueue side
  logic              inBusy, inKeep;
  logic [VC_W-1:0]   inVcR;
  logic [SLOT_W-1:0] inSlot;
  logic [WIDX_W-1:0] inWord;
  // Dequeue side
  logic              busy;
  logic [SLOT_W-1:0] curSlot;
  logic [WIDX_W-1:0] outWord;
  logic [PORT_W-1:0] outPortR, rrPtr, selPort;
  logic [VC_W-1:0]   outVcR, selVc;
  logic [Q_W-1:0]    selQ, commitQ;
  logic [SLOT_W-1:0] allocSlot, selSlot;
  logic freeAny, sofNow, acceptNow, commit, found, reapp, startDeq;

  function automatic int qOf(input logic [PORT_W-1:0] p, input logic [PRIO_W-1:0] pr);
    return int'(p) * NUM_PRIO + int'(pr);
  endfunction

  always_comb begin
    allocSlot = '0;
    for (int i = BUF_CELLS - 1; i >= 0; i--)
      if (freeMask[i]) allocSlot = SLOT_W'(i);
  end

  assign freeAny   = |freeMask;
  assign sofNow    = inValid && inSof;
  assign acceptNow = sofNow && freeAny && (vcLen[inVc] < vcLimit[inVc]);
  assign commit    = inValid && !inSof && inBusy && inKeep && (inWord == LAST_WORD);
  assign commitQ   = Q_W'(qOf(vcPort[inVcR], vcPrio[inVcR]));

  // Port rotation, then the highest non-empty priority on the chosen port
  always_comb begin
    int  pi;
    logic hit;
    found = 1'b0; selPort = '0; selQ = '0;
    for (int off = 0; off < NUM_PORT; off++) begin
      pi = int'(rrPtr) + off;
      if (pi >= NUM_PORT) pi = pi - NUM_PORT;
      hit = 1'b0;
      if (!found && portReady[pi]) begin
        for (int pr = 0; pr < NUM_PRIO; pr++)
          if (qValid[pi * NUM_PRIO + pr]) begin
            hit  = 1'b1;
            selQ = Q_W'(pi * NUM_PRIO + pr);
          end
        if (hit) begin
          found   = 1'b1;
          selPort = PORT_W'(pi);
        end
      end
    end
  end

  assign selVc    = qHead[selQ];
  assign selSlot  = vcHead[selVc];
  assign reapp    = vcLen[selVc] > LEN_W'(1);
  assign startDeq = !busy && !commit && found;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= '1;
      qValid   <= '0;
      inBusy <= 1'b0; inKeep <= 1'b0; inVcR <= '0; inSlot <= '0; inWord <= '0;
      busy <= 1'b0; curSlot <= '0; outWord <= '0; outPortR <= '0; outVcR <= '0; rrPtr <= '0;
      for (int i = 0; i < BUF_CELLS; i++) cellNext[i] <= '0;
      for (int q = 0; q < NUM_Q; q++) begin qHead[q] <= '0; qTail[q] <= '0; end
      for (int v = 0; v < NUM_VC; v++) begin
        vcHead[v] <= '0; vcTail[v] <= '0; vcLen[v] <= '0; vcMax[v] <= '0;
        vcLimit[v] <= LEN_W'(BUF_CELLS); vcLoss[v] <= '0; vcPort[v] <= '0;
        vcPrio[v] <= '0; svcNext[v] <= '0;
      end
    end else begin
      // Arrival: claim a slot or count a loss on the first word
      if (sofNow) begin
        inBusy <= 1'b1; inVcR <= inVc; inWord <= WIDX_W'(1);
        inKeep <= acceptNow; inSlot <= allocSlot;
        if (acceptNow) freeMask[allocSlot] <= 1'b0;
        else if (vcLoss[inVc] != '1) vcLoss[inVc] <= vcLoss[inVc] + 1'b1;
      end else if (inValid && inBusy) begin
        inWord <= inWord + 1'b1;
        if (inWord == LAST_WORD) inBusy <= 1'b0;
      end
      // Link a fully written cell onto its circuit's chain
      if (commit) begin
        if (vcLen[inVcR] == '0) begin
          vcHead[inVcR] <= inSlot;
          if (!qValid[commitQ]) begin
            qHead[commitQ]  <= inVcR;
            qValid[commitQ] <= 1'b1;
          end else svcNext[qTail[commitQ]] <= inVcR;
          qTail[commitQ] <= inVcR;
        end else cellNext[vcTail[inVcR]] <= inSlot;
        vcTail[inVcR] <= inSlot;
        vcLen[inVcR]  <= vcLen[inVcR] + 1'b1;
        if (vcLen[inVcR] + 1'b1 > vcMax[inVcR]) vcMax[inVcR] <= vcLen[inVcR] + 1'b1;
      end
      // Departure: pop a circuit, pop its head cell, rotate the circuit
      if (startDeq) begin
        busy <= 1'b1; curSlot <= selSlot; outWord <= '0;
        outPortR <= selPort; outVcR <= selVc;
        rrPtr <= (int'(selPort) == NUM_PORT - 1) ? '0 : selPort + 1'b1;
        vcHead[selVc] <= cellNext[selSlot];
        vcLen[selVc]  <= vcLen[selVc] - 1'b1;
        if (reapp) begin
          if (qHead[selQ] != qTail[selQ]) begin
            qHead[selQ] <= svcNext[qHead[selQ]];
            svcNext[qTail[selQ]] <= selVc;
            qTail[selQ] <= selVc;
          end
        end else if (qHead[selQ] == qTail[selQ]) qValid[selQ] <= 1'b0;
        else qHead[selQ] <= svcNext[qHead[selQ]];
      end else if (busy) begin
        if (outWord == LAST_WORD) begin
          busy <= 1'b0;
          freeMask[curSlot] <= 1'b1;
        end else outWord <= outWord + 1'b1;
      end
      if (cfgWe) begin
        vcPort[cfgVc] <= cfgPort; vcPrio[cfgVc] <= cfgPrio; vcLimit[cfgVc] <= cfgLimit;
        vcMax[cfgVc] <= '0; vcLoss[cfgVc] <= '0;
      end
    end
  end

  assign outValid = busy;
  assign outSof   = busy && (outWord == '0);
  assign outEop   = busy && (outWord == LAST_WORD);
  assign outPort  = outPortR;
  assign outVc    = outVcR;
  assign statLen  = vcLen[statVc];
  assign statMax  = vcMax[statVc];
  assign statLoss = vcLoss[statVc];

  assign stb.wrEn   = acceptNow || (inValid && !inSof && inBusy && inKeep);
  assign stb.wrSlot = sofNow ? allocSlot : inSlot;
  assign stb.wrWord = sofNow ? '0 : inWord;
  assign stb.rdSlot = curSlot;
  assign stb.rdWord = outWord;

  logic [NUM_PORT-1:0] readyQ;
  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= '0;
    else readyQ <= portReady;
  end

  AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !outEop) |=> outValid); // R1
  AST_READY_AT_PICK: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> readyQ[outPort]); // R3
  AST_LIMIT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && vcLen[inVc] >= vcLimit[inVc]) |=> !inKeep); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && freeMask == '0) |=> !inKeep); // R8
endmodule

// File: rtl/vc_cell_queue.sv
module vc_cell_queue
  import vc_cell_queue_pkg::*;
#(
  parameter int NUM_VC   = 8,
  parameter int NUM_PORT = 4,
  parameter int NUM_PRIO = 2,
  parameter int LOSS_W   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inSof,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     inVc,
  input  logic [WORD_W-1:0]                            inData,
  input  logic cfgWe,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     cfgVc,
  input  logic [((NUM_PORT>1)?$clog2(NUM_PORT):1)-1:0] cfgPort,
  input  logic [((NUM_PRIO>1)?$clog2(NUM_PRIO):1)-1:0] cfgPrio,
  input  logic [$clog2(BUF_CELLS+1)-1:0]               cfgLimit,
  input  logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     statVc,
  output logic [$clog2(BUF_CELLS+1)-1:0]               statLen,
  output logic [$clog2(BUF_CELLS+1)-1:0]               statMax,
  output logic [LOSS_W-1:0]                            statLoss,
  input  logic [NUM_PORT-1:0]                          portReady,
  output logic outValid,
  output logic outSof,
  output logic outEop,
  output logic [((NUM_PORT>1)?$clog2(NUM_PORT):1)-1:0] outPort,
  output logic [((NUM_VC>1)?$clog2(NUM_VC):1)-1:0]     outVc,
  output logic [WORD_W-1:0]                            outData
);
  memStrobe_t stb;

  vc_queue_ctrl #(
    .NUM_VC(NUM_VC), .NUM_PORT(NUM_PORT), .NUM_PRIO(NUM_PRIO), .LOSS_W(LOSS_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inVc(inVc),
    .cfgWe(cfgWe), .cfgVc(cfgVc), .cfgPort(cfgPort), .cfgPrio(cfgPrio), .cfgLimit(cfgLimit),
    .statVc(statVc), .statLen(statLen), .statMax(statMax), .statLoss(statLoss),
    .portReady(portReady), .outValid(outValid), .outSof(outSof), .outEop(outEop),
    .outPort(outPort), .outVc(outVc), .stb(stb)
  );

  vc_cell_store i_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(inData), .rdData(outData)
  );
endmodule

// File: tb/test_vc_cell_queue.sv
module test_vc_cell_queue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0;
  logic [2:0] inVc = '0;
  logic [31:0] inData = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgVc = '0;
  logic [1:0] cfgPort = '0;
  logic [0:0] cfgPrio = '0;
  logic [4:0] cfgLimit = '0;
  logic [2:0] statVc = '0;
  logic [4:0] statLen, statMax;
  logic [7:0] statLoss;
  logic [3:0] portReady = '0;
  logic outValid, outSof, outEop;
  logic [1:0] outPort;
  logic [2:0] outVc;
  logic [31:0] outData;

  int checks = 0, fails = 0;
  int recCnt = 0;
  int recTag [256];
  int recVc [256];
  int recPort [256];
  int monWord = 0;
  int monTag = 0;
  bit monOk = 1'b1;

  vc_cell_queue i_vc_cell_queue (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inVc(inVc), .inData(inData),
    .cfgWe(cfgWe), .cfgVc(cfgVc), .cfgPort(cfgPort), .cfgPrio(cfgPrio), .cfgLimit(cfgLimit),
    .statVc(statVc), .statLen(statLen), .statMax(statMax), .statLoss(statLoss),
    .portReady(portReady), .outValid(outValid), .outSof(outSof), .outEop(outEop),
    .outPort(outPort), .outVc(outVc), .outData(outData)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Output monitor: rebuilds each cell and checks its words (R1)
  always @(negedge clk) begin
    if (outValid) begin
      if (outSof) begin
        monWord = 0;
        monOk = 1'b1;
        monTag = int'(outData[31:16]);
      end
      if (outData != {monTag[15:0], 5'd0, outVc, monWord[7:0]}) monOk = 1'b0;
      if (outEop) begin
        check(monOk && monWord == 13, "R1", "cell words intact, length", monWord + 1, 14);
        recTag[recCnt] = monTag;
        recVc[recCnt] = int'(outVc);
        recPort[recCnt] = int'(outPort);
        recCnt++;
      end
      monWord++;
    end
  end

  task automatic sendCell(input int vc, input int tag);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      inValid = 1'b1;
      inSof = (k == 0);
      inVc = 3'(vc);
      inData = {tag[15:0], 5'd0, 3'(vc), 8'(k)};
    end
    @(negedge clk);
    inValid = 1'b0;
    inSof = 1'b0;
  endtask

  task automatic configure(input int vc, input int port, input int prio, input int limit);
    @(negedge clk);
    cfgWe = 1'b1; cfgVc = 3'(vc); cfgPort = 2'(port); cfgPrio = 1'(prio); cfgLimit = 5'(limit);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitCells(input int target, input string req);
    int n;
    n = 0;
    while (recCnt < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(recCnt >= target, req, "cells received", recCnt, target);
  endtask

  task automatic readStat(input int vc);
    @(negedge clk);
    statVc = 3'(vc);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);
    for (int v = 0; v < 8; v++) begin
      readStat(v);
      check(statLen == 0 && statLoss == 0, "R10", "length and loss after reset",
            int'(statLen) + int'(statLoss), 0);
    end
  endtask

  task automatic testOrder();
    int b;
    b = recCnt;
    configure(0, 0, 0, 8);
    portReady = 4'b0000;
    sendCell(0, 1); sendCell(0, 2); sendCell(0, 3);
    readStat(0);
    check(statLen == 3, "R9", "length with three cells", int'(statLen), 3);
    portReady = 4'b0001;
    waitCells(b + 3, "R2");
    for (int i = 0; i < 3; i++)
      check(recTag[b + i] == i + 1 && recPort[b + i] == 0, "R2", "arrival order tag", recTag[b + i], i + 1);
    readStat(0);
    check(statLen == 0, "R9", "length after drain", int'(statLen), 0);
    check(statMax == 3, "R9", "high-water mark", int'(statMax), 3);
    configure(0, 0, 0, 8);
    readStat(0);
    check(statMax == 0, "R9", "high-water mark cleared by config", int'(statMax), 0);
    portReady = 4'b0000;
  endtask

  task automatic testNoHol();
    int b;
    b = recCnt;
    configure(1, 1, 0, 8);
    configure(2, 2, 0, 8);
    sendCell(1, 10); sendCell(2, 20);
    portReady = 4'b0100;
    repeat (80) @(negedge clk);
    check(recCnt == b + 1, "R3", "only the ready port sends", recCnt - b, 1);
    check(recVc[b] == 2, "R3", "circuit on ready port passes", recVc[b], 2);
    portReady = 4'b0110;
    waitCells(b + 2, "R3");
    check(recTag[b + 1] == 10, "R3", "waiting cell leaves once ready", recTag[b + 1], 10);
    portReady = 4'b0000;
  endtask

  task automatic testPriority();
    int b;
    int exp [4] = '{40, 41, 30, 31};
    b = recCnt;
    configure(3, 3, 0, 8);
    configure(4, 3, 1, 8);
    sendCell(3, 30); sendCell(3, 31); sendCell(4, 40); sendCell(4, 41);
    portReady = 4'b1000;
    waitCells(b + 4, "R4");
    for (int i = 0; i < 4; i++)
      check(recTag[b + i] == exp[i], "R4", "priority order tag", recTag[b + i], exp[i]);
    portReady = 4'b0000;
  endtask

  task automatic testTurns();
    int b;
    int exp [4] = '{50, 60, 51, 61};
    b = recCnt;
    configure(5, 0, 1, 8);
    configure(6, 0, 1, 8);
    sendCell(5, 50); sendCell(5, 51); sendCell(6, 60); sendCell(6, 61);
    portReady = 4'b0001;
    waitCells(b + 4, "R5");
    for (int i = 0; i < 4; i++)
      check(recTag[b + i] == exp[i], "R5", "equal-priority turn tag", recTag[b + i], exp[i]);
    portReady = 4'b0000;
  endtask

  task automatic testRotation();
    int b;
    b = recCnt;
    configure(0, 0, 0, 8);
    configure(1, 1, 0, 8);
    sendCell(0, 80); sendCell(0, 81); sendCell(1, 90); sendCell(1, 91);
    portReady = 4'b0011;
    waitCells(b + 4, "R6");
    for (int i = 0; i < 3; i++)
      check(recPort[b + i] != recPort[b + i + 1], "R6", "ports alternate", recPort[b + i + 1], 1 - recPort[b + i]);
    // Port 1 follows port 0 in the rotation left by the previous scenario
    check(recPort[b] == 1, "R6", "first port in rotation", recPort[b], 1);
    portReady = 4'b0000;
  endtask

  task automatic testLimit();
    int b;
    b = recCnt;
    configure(7, 2, 0, 2);
    sendCell(7, 70); sendCell(7, 71); sendCell(7, 72);
    readStat(7);
    check(statLen == 2, "R7", "length held at limit", int'(statLen), 2);
    check(statLoss == 1, "R7", "loss counter", int'(statLoss), 1);
    portReady = 4'b0100;
    waitCells(b + 2, "R7");
    repeat (60) @(negedge clk);
    check(recCnt == b + 2, "R7", "dropped cell never sent", recCnt - b, 2);
    check(recTag[b + 1] == 71, "R7", "last kept tag", recTag[b + 1], 71);
    portReady = 4'b0000;
  endtask

  task automatic testFull();
    int b;
    b = recCnt;
    configure(0, 0, 0, 16);
    configure(1, 1, 0, 16);
    for (int i = 0; i < 16; i++) sendCell(0, 100 + i);
    sendCell(1, 200);
    readStat(0);
    check(statLen == 16, "R8", "store holds sixteen cells", int'(statLen), 16);
    readStat(1);
    check(statLen == 0 && statLoss == 1, "R8", "arrival into full store dropped",
          int'(statLoss), 1);
    portReady = 4'b0001;
    waitCells(b + 16, "R8");
    for (int i = 0; i < 16; i++)
      check(recTag[b + i] == 100 + i, "R2", "deep chain order", recTag[b + i], 100 + i);
    sendCell(1, 201);
    portReady = 4'b0011;
    waitCells(b + 17, "R8");
    check(recTag[b + 16] == 201, "R8", "freed slot reused", recTag[b + 16], 201);
    portReady = 4'b0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOrder();
    testNoHol();
    testPriority();
    testTurns();
    testRotation();
    testLimit();
    testFull();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule